// File: doc/BRIEF.md
# Store Queue with Load Address Disambiguation

This block keeps every store that has left decode but not yet reached memory, in the order the program issued them. Each slot holds the store's reorder tag, its address and its data. The address and the data come in separately, on their own write ports, each whenever its producer has it. Slots are allocated at the tail. The commit port retires stores one at a time in program order. A committed store then drains from the head to the memory write port, one store per cycle.

When a load issues, it reads the queue's tail pointer and keeps it. That value, called the mark, separates the stores older than the load from all later ones. When the load has its address, it presents the mark and the address on the query port. In the same cycle the queue answers with one of four results:

- stall, if an older store's address is still unknown;
- forward the data of the youngest older store with a matching address;
- forward the reorder tag of that store, if its data has not arrived yet;
- go to memory, if no older store matches.

A flush discards every store that has not committed. Committed stores still drain to memory after a flush.

Top module: `store_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `full` is 0, `tail_ptr` is 0, `mem_wr_en` is 0, and a load query with any mark answers go-to-memory (`ld_resp` = 3).
- R2: Each accepted allocation takes the slot given by `alloc_slot` (tail modulo 8) and advances `tail_ptr` by one. After 8 live stores `full` is 1. An allocation while full is ignored: `tail_ptr` does not change.
- R3: A load query answers stall (`ld_resp` = 0) when any store older than the mark has no address yet.
- R4: When an older store's address equals the load address and that store's data is present, the answer is forward-data (`ld_resp` = 1) and `ld_data` carries the store data.
- R5: When the matching older store has no data yet, the answer is forward-tag (`ld_resp` = 2) and `ld_tag` carries that store's reorder tag.
- R6: When several older stores match the load address, the youngest of them supplies the answer.
- R7: Stores at or after the load's mark do not affect the answer, even when their address matches or is unknown.
- R8: When all older store addresses are known and none matches, the answer is go-to-memory (`ld_resp` = 3). The same holds with `ld_valid` low.
- R9: A commit retires the oldest uncommitted store only if that store has both its address and its data; otherwise the commit is ignored. A store committed at clock edge N appears on `mem_wr_en`/`mem_wr_addr`/`mem_wr_data` after edge N+1 at the earliest. Committed stores reach memory in program order, one per cycle.
- R10: A flush sets `tail_ptr` to the commit point and discards every uncommitted store. Stores committed before the flush still drain to memory. A flush overrides an allocation or a commit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_tag | input | 5 | Reorder tag of the allocated store |
| alloc_slot | output | 3 | Slot the next allocation will take |
| tail_ptr | output | 4 | Tail pointer with wrap bit; a load keeps this value as its mark |
| full | output | 1 | All 8 slots hold live stores |
| addr_we | input | 1 | Store address write strobe |
| addr_slot | input | 3 | Slot receiving the address |
| addr_val | input | 16 | Store address |
| data_we | input | 1 | Store data write strobe |
| data_slot | input | 3 | Slot receiving the data |
| data_val | input | 16 | Store data |
| ld_valid | input | 1 | Load query present |
| ld_mark | input | 4 | Tail pointer the load kept at issue |
| ld_addr | input | 16 | Load address |
| ld_resp | output | 2 | 0 stall, 1 forward data, 2 forward tag, 3 memory |
| ld_data | output | 16 | Forwarded store data |
| ld_tag | output | 5 | Tag of the pending data producer |
| commit_valid | input | 1 | Retire the oldest uncommitted store |
| flush | input | 1 | Discard all uncommitted stores |
| mem_wr_en | output | 1 | Committed store write to memory |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 16 | Memory write data |

## Verification
The hardest case to reach is a query that must sort older from younger stores. It needs several live stores with the same address, some on each side of the load's mark, and some with their data or address still missing. The stimulus builds this by allocating four stores and recording the tail part-way through. It then gives three of them one shared address with different data and leaves the fourth unaddressed. The same address is then queried with marks 0, 1 and 2. A second hard case is a flush in the cycle just after a commit, while that committed store has not yet drained. The bench lines this up edge by edge so that it can see the surviving store's memory write.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int SQ_DEPTH = 8;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 16;
    localparam int TAG_W    = 5;
    localparam int PTR_W    = $clog2(SQ_DEPTH);
    localparam int PW       = PTR_W + 1;

    typedef enum logic [1:0] {
        RESP_STALL = 2'd0,
        RESP_DATA  = 2'd1,
        RESP_TAG   = 2'd2,
        RESP_MEM   = 2'd3
    } ld_resp_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              addr_ok;
        logic              data_ok;
    } sq_entry_t;

    // distance from older pointer b to newer pointer a, wrap bit included
    function automatic logic [PW-1:0] ptr_span(input logic [PW-1:0] a, input logic [PW-1:0] b);
        return a - b;
    endfunction
endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs
    import sq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_req,
    input  logic          commit_req,
    input  logic          cmt_complete,
    input  logic          flush,
    output logic [PW-1:0] head,
    output logic [PW-1:0] cmt,
    output logic [PW-1:0] tail,
    output logic          full,
    output logic          alloc_fire,
    output logic          drain_fire
);
    logic [PW-1:0] live_cnt;
    logic          commit_fire;

    assign live_cnt    = ptr_span(tail, head);
    assign full        = (live_cnt == PW'(SQ_DEPTH));
    assign alloc_fire  = alloc_req && !full && !flush;
    assign commit_fire = commit_req && !flush && (cmt != tail) && cmt_complete;
    assign drain_fire  = (head != cmt);

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            cmt  <= '0;
            tail <= '0;
        end else begin
            if (drain_fire)  head <= head + 1'b1;
            if (commit_fire) cmt  <= cmt + 1'b1;
            if (flush)           tail <= cmt;
            else if (alloc_fire) tail <= tail + 1'b1;
        end
    end

    // R2
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_span(tail, head) <= PW'(SQ_DEPTH));

    // R9
    commit_order_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_span(cmt, head) <= ptr_span(tail, head));

    // R2
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (full && alloc_req && !flush) |=> $stable(tail));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ptr_span(tail, cmt) == '0));
endmodule

// File: rtl/sq_store_array.sv
module sq_store_array
    import sq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_fire,
    input  logic [PTR_W-1:0]  alloc_idx,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              addr_we,
    input  logic [PTR_W-1:0]  addr_idx,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              data_we,
    input  logic [PTR_W-1:0]  data_idx,
    input  logic [DATA_W-1:0] data_val,
    output sq_entry_t         ents [SQ_DEPTH]
);
    for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else begin
                if (alloc_fire && alloc_idx == PTR_W'(g)) begin
                    ents[g].tag     <= alloc_tag;
                    ents[g].addr_ok <= 1'b0;
                    ents[g].data_ok <= 1'b0;
                end
                if (addr_we && addr_idx == PTR_W'(g)) begin
                    ents[g].addr    <= addr_val;
                    ents[g].addr_ok <= 1'b1;
                end
                if (data_we && data_idx == PTR_W'(g)) begin
                    ents[g].data    <= data_val;
                    ents[g].data_ok <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sq_search.sv
module sq_search
    import sq_pkg::*;
(
    input  sq_entry_t         ents [SQ_DEPTH],
    input  logic [PW-1:0]     head,
    input  logic [PW-1:0]     tail,
    input  logic              ld_valid,
    input  logic [PW-1:0]     ld_mark,
    input  logic [ADDR_W-1:0] ld_addr,
    output ld_resp_e          resp,
    output logic [DATA_W-1:0] fwd_data,
    output logic [TAG_W-1:0]  fwd_tag
);
    logic [PW-1:0]    older_raw;
    logic [PW-1:0]    older_cnt;
    logic             any_unknown;
    logic             hit;
    logic [PTR_W-1:0] hit_idx;

    // a mark behind the head means every older store already drained
    assign older_raw = ptr_span(ld_mark, head);
    assign older_cnt = (older_raw > ptr_span(tail, head)) ? '0 : older_raw;

    // walk oldest to youngest so the last match kept is the youngest
    always_comb begin
        any_unknown = 1'b0;
        hit         = 1'b0;
        hit_idx     = '0;
        for (int p = 0; p < SQ_DEPTH; p++) begin
            if (PW'(p) < older_cnt) begin
                if (!ents[head[PTR_W-1:0] + PTR_W'(p)].addr_ok) begin
                    any_unknown = 1'b1;
                end else if (ents[head[PTR_W-1:0] + PTR_W'(p)].addr == ld_addr) begin
                    hit     = 1'b1;
                    hit_idx = head[PTR_W-1:0] + PTR_W'(p);
                end
            end
        end
    end

    always_comb begin
        resp     = RESP_MEM;
        fwd_data = '0;
        fwd_tag  = '0;
        if (ld_valid) begin
            if (any_unknown) begin
                resp = RESP_STALL;
            end else if (hit && ents[hit_idx].data_ok) begin
                resp     = RESP_DATA;
                fwd_data = ents[hit_idx].data;
            end else if (hit) begin
                resp    = RESP_TAG;
                fwd_tag = ents[hit_idx].tag;
            end
        end
    end

    // R4
    fwd_only_on_match_chk: assert final (!(ld_valid && resp == RESP_DATA) || (hit && !any_unknown));
endmodule

// File: rtl/store_queue.sv
module store_queue
    import sq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic [PTR_W-1:0]  alloc_slot,
    output logic [PW-1:0]     tail_ptr,
    output logic              full,
    input  logic              addr_we,
    input  logic [PTR_W-1:0]  addr_slot,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              data_we,
    input  logic [PTR_W-1:0]  data_slot,
    input  logic [DATA_W-1:0] data_val,
    input  logic              ld_valid,
    input  logic [PW-1:0]     ld_mark,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [1:0]        ld_resp,
    output logic [DATA_W-1:0] ld_data,
    output logic [TAG_W-1:0]  ld_tag,
    input  logic              commit_valid,
    input  logic              flush,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    logic [PW-1:0] head, cmt, tail;
    logic          alloc_fire, drain_fire, cmt_complete;
    sq_entry_t     ents [SQ_DEPTH];
    ld_resp_e      resp;

    assign cmt_complete = ents[cmt[PTR_W-1:0]].addr_ok && ents[cmt[PTR_W-1:0]].data_ok;

    sq_ptrs i_ptrs (
        .clk(clk), .rst(rst), .alloc_req(alloc_valid), .commit_req(commit_valid),
        .cmt_complete(cmt_complete), .flush(flush), .head(head), .cmt(cmt),
        .tail(tail), .full(full), .alloc_fire(alloc_fire), .drain_fire(drain_fire)
    );

    sq_store_array i_array (
        .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_idx(tail[PTR_W-1:0]),
        .alloc_tag(alloc_tag), .addr_we(addr_we), .addr_idx(addr_slot), .addr_val(addr_val),
        .data_we(data_we), .data_idx(data_slot), .data_val(data_val), .ents(ents)
    );

    sq_search i_search (
        .ents(ents), .head(head), .tail(tail), .ld_valid(ld_valid), .ld_mark(ld_mark),
        .ld_addr(ld_addr), .resp(resp), .fwd_data(ld_data), .fwd_tag(ld_tag)
    );

    assign ld_resp    = resp;
    assign alloc_slot = tail[PTR_W-1:0];
    assign tail_ptr   = tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            mem_wr_en <= drain_fire;
            if (drain_fire) begin
                mem_wr_addr <= ents[head[PTR_W-1:0]].addr;
                mem_wr_data <= ents[head[PTR_W-1:0]].data;
            end
        end
    end

    // R9
    drain_complete_chk: assert property (@(posedge clk) disable iff (rst)
        drain_fire |-> (ents[head[PTR_W-1:0]].addr_ok && ents[head[PTR_W-1:0]].data_ok));
endmodule

// File: tb/test_store_queue.sv
`timescale 1ns/1ps
module test_store_queue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 0;
    logic [4:0]  alloc_tag = 0;
    logic [2:0]  alloc_slot;
    logic [3:0]  tail_ptr;
    logic        full;
    logic        addr_we = 0;
    logic [2:0]  addr_slot = 0;
    logic [15:0] addr_val = 0;
    logic        data_we = 0;
    logic [2:0]  data_slot = 0;
    logic [15:0] data_val = 0;
    logic        ld_valid = 0;
    logic [3:0]  ld_mark = 0;
    logic [15:0] ld_addr = 0;
    logic [1:0]  ld_resp;
    logic [15:0] ld_data;
    logic [4:0]  ld_tag;
    logic        commit_valid = 0;
    logic        flush = 0;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [15:0] mem_wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    store_queue i_store_queue (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic alloc(input logic [4:0] t);
        alloc_valid = 1; alloc_tag = t;
        tick();
        alloc_valid = 0;
    endtask

    task automatic wr_addr(input logic [2:0] s, input logic [15:0] a);
        addr_we = 1; addr_slot = s; addr_val = a;
        tick();
        addr_we = 0;
    endtask

    task automatic wr_data(input logic [2:0] s, input logic [15:0] d);
        data_we = 1; data_slot = s; data_val = d;
        tick();
        data_we = 0;
    endtask

    task automatic query(input logic [3:0] m, input logic [15:0] a);
        ld_valid = 1; ld_mark = m; ld_addr = a;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 full", full, 0);
        chk("R1 tail", tail_ptr, 0);
        chk("R1 mem_wr_en", mem_wr_en, 0);
        query(4'd0, 16'h1234);
        chk("R1 resp", ld_resp, 3);
        ld_valid = 0;
    endtask

    task automatic t_basic();
        do_reset();
        alloc(5'd3);
        chk("R2 slot after one", alloc_slot, 1);
        query(4'd1, 16'h0040);
        chk("R3 stall unknown addr", ld_resp, 0);
        wr_addr(3'd0, 16'h0040);
        query(4'd1, 16'h0040);
        chk("R5 tag resp", ld_resp, 2);
        chk("R5 tag value", ld_tag, 3);
        wr_data(3'd0, 16'hBEEF);
        query(4'd1, 16'h0040);
        chk("R4 data resp", ld_resp, 1);
        chk("R4 data value", ld_data, 16'hBEEF);
        query(4'd1, 16'h0044);
        chk("R8 no match", ld_resp, 3);
        ld_valid = 0; #1;
        chk("R8 idle resp", ld_resp, 3);
    endtask

    task automatic t_youngest();
        do_reset();
        alloc(5'd1); alloc(5'd2); alloc(5'd3); alloc(5'd4);
        wr_addr(3'd0, 16'h0010); wr_data(3'd0, 16'h1111);
        wr_addr(3'd1, 16'h0010); wr_data(3'd1, 16'h2222);
        wr_addr(3'd2, 16'h0010); wr_data(3'd2, 16'h3333);
        query(4'd2, 16'h0010);
        chk("R6 youngest older wins", ld_data, 16'h2222);
        chk("R7 younger unknown ignored", ld_resp, 1);
        query(4'd1, 16'h0010);
        chk("R7 mark 1 data", ld_data, 16'h1111);
        query(4'd0, 16'h0010);
        chk("R7 mark 0 memory", ld_resp, 3);
        query(4'd4, 16'h0010);
        chk("R3 stall from slot 3", ld_resp, 0);
        ld_valid = 0;
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 8; i++) alloc(5'(i));
        chk("R2 full", full, 1);
        chk("R2 tail at 8", tail_ptr, 8);
        alloc(5'd9);
        chk("R2 alloc ignored when full", tail_ptr, 8);
        query(4'd8, 16'h0000);
        chk("R3 stall full queue", ld_resp, 0);
        ld_valid = 0;
    endtask

    task automatic t_commit();
        do_reset();
        alloc(5'd1); alloc(5'd2);
        wr_addr(3'd0, 16'h0020); wr_data(3'd0, 16'h00A0);
        wr_addr(3'd1, 16'h0030);
        commit_valid = 1; tick(); commit_valid = 0;
        chk("R9 no write the cycle after commit", mem_wr_en, 0);
        tick();
        chk("R9 write s0", mem_wr_en, 1);
        chk("R9 addr s0", mem_wr_addr, 16'h0020);
        chk("R9 data s0", mem_wr_data, 16'h00A0);
        commit_valid = 1; tick(); commit_valid = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R9 incomplete commit ignored", mem_wr_en, 0);
        end
        wr_data(3'd1, 16'h00B0);
        alloc(5'd3);
        wr_addr(3'd2, 16'h0040); wr_data(3'd2, 16'h00C0);
        commit_valid = 1; tick(); tick(); commit_valid = 0;
        chk("R9 order first", mem_wr_addr, 16'h0030);
        chk("R9 order first data", mem_wr_data, 16'h00B0);
        tick();
        chk("R9 order second", mem_wr_addr, 16'h0040);
        chk("R9 order second en", mem_wr_en, 1);
        tick();
        chk("R9 drain idle", mem_wr_en, 0);
    endtask

    task automatic t_flush();
        do_reset();
        alloc(5'd1); alloc(5'd2);
        wr_addr(3'd0, 16'h0050); wr_data(3'd0, 16'h0055);
        wr_addr(3'd1, 16'h0060); wr_data(3'd1, 16'h0066);
        commit_valid = 1; tick();
        flush = 1; alloc_valid = 1; alloc_tag = 5'd7;
        tick();
        flush = 0; alloc_valid = 0; commit_valid = 0;
        chk("R10 committed store still written", mem_wr_en, 1);
        chk("R10 committed addr", mem_wr_addr, 16'h0050);
        chk("R10 tail at commit point", tail_ptr, 1);
        chk("R10 next slot", alloc_slot, 1);
        query(4'd2, 16'h0060);
        chk("R10 flushed store not seen", ld_resp, 3);
        ld_valid = 0;
        tick();
        chk("R10 nothing more written", mem_wr_en, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_youngest();
        t_full();
        t_commit();
        t_flush();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule